// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block is a timekeeping core that shares one byte-wide memory space with general RAM. The eight highest byte addresses hold the calendar: seconds, minutes, hours, day of week, date, month, year and century, each as packed BCD. Every address below that window reaches a plain RAM array. Software reaches both through a synchronous version of an asynchronous SRAM port. The port has active-low chip, output and write enables, an address bus, and separate byte buses for data in and data out, with a drive-enable flag.

A one-pulse-per-second tick advances the counter chain. Three control bits sit in spare bits of the clock bytes. A stop bit halts counting. A load bit holds the counters so software can write a new time, and that time is transferred in one step when the bit clears. A freeze bit holds a read image steady while the counters keep running underneath. A frequency-test bit is stored and read back. A battery-good flag always reads as 1.

Top module: `bcd_rtc_bank`

## Requirements
- R1: Clock window, by offset from the lowest window address: 0 = {load bit7, freeze bit6, century bits5:0}, 1 = {stop bit7, seconds}, 2 = minutes, 3 = hours, 4 = {battery flag bit7 (always 1), frequency-test bit6, zeros bits5:3, day of week}, 5 = date, 6 = month, 7 = year. Unused bits read as 0.
- R2: dq_oe is 1 only while ce_n=0, oe_n=0 and we_n=1, and dq_out then carries the addressed byte. dq_oe drops as soon as we_n goes low, even when oe_n stays low.
- R3: A write commits once, in the first cycle in which ce_n and we_n are both low, whichever of them fell last, and uses the data on dq_in in that cycle. The address must stay constant while the write is held.
- R4: Addresses below the clock window read back the last byte written to them.
- R5: Each tick advances seconds 00-59, which carry into minutes 00-59, which carry into hours 00-23.
- R6: When hours roll from 23 to 00, date advances and day of week advances, with day 07 wrapping to 01.
- R7: Date wraps to 01 after the month's last day: 31, 30 for months 04/06/09/11, and for February 29 when the year is divisible by 4, otherwise 28.
- R8: Month 12 carries into year, year 99 carries into century, and century 39 wraps to 00.
- R9: While the stop bit is 1, ticks change no field. Counting resumes after the bit is cleared.
- R10: While the load bit is 1, ticks are ignored and written fields read back as written. Clearing the load bit moves all loaded fields, including the century written with the load bit, into the counters at once.
- R11: While the freeze bit is 1, reads return the values from the moment it was set, while the counters keep advancing. After the bit clears, reads show the live count.
- R12: With the load bit at 0, writes to time fields have no effect, while the stop and frequency-test bits in those bytes still take effect.
- R13: After reset the clock reads 00:00:00, day 01, date 01, month 01, year 00, century 00, with all control bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data, 0 when not driving |
| dq_oe | output | 1 | Read data drive enable |

## Verification
The bench sets times just before each rollover: the end of a 30-day month, February in leap and non-leap years, December 31 of year 99, and century 39. A chain with a wrong month table or leap rule would give a wrong date, and a missing carry would leave the year or century unchanged. It also covers each control bit. A stop bit that leaks ticks, a load bit that lets counting continue or loses the century byte, and a freeze image that follows the live count would all show up as wrong read values. Writes held over several cycles with changing data, and output enable held low into a write, catch double commits and bus contention. Random legal start times with random tick counts are compared against a calendar model in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] cen;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] mins;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET = '{cen: 8'h00, yr: 8'h00, mon: 8'h01, date: 8'h01,
                                      dow: 8'h01, hr: 8'h00, mins: 8'h00, sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // last legal date of a month, BCD
  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    logic [1:0] m4;
    m4 = {yr[4], 1'b0} + yr[1:0];  // year mod 4 (tens*10 mod 4 = 2*tens[0])
    case (mon)
      8'h02:                      return (m4 == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic bcd_ok(input logic [7:0] v, input logic [7:0] lo, input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  function automatic logic time_ok(input rtc_time_t t);
    return bcd_ok(t.sec, 8'h00, 8'h59) && bcd_ok(t.mins, 8'h00, 8'h59) &&
           bcd_ok(t.hr, 8'h00, 8'h23) && bcd_ok(t.dow, 8'h01, 8'h07) &&
           bcd_ok(t.date, 8'h01, month_last(t.mon, t.yr)) && bcd_ok(t.mon, 8'h01, 8'h12) &&
           bcd_ok(t.yr, 8'h00, 8'h99) && bcd_ok(t.cen, 8'h00, 8'h39);
  endfunction

endpackage

// File: rtl/rtc_chain.sv
module rtc_chain
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  input  logic      adv,
  output rtc_time_t nxt
);

  logic c_sec, c_min, c_hr, c_date, c_mon, c_yr;

  always_comb begin
    c_sec  = adv && (cur.sec == 8'h59);
    c_min  = c_sec && (cur.mins == 8'h59);
    c_hr   = c_min && (cur.hr == 8'h23);
    c_date = c_hr && (cur.date == month_last(cur.mon, cur.yr));
    c_mon  = c_date && (cur.mon == 8'h12);
    c_yr   = c_mon && (cur.yr == 8'h99);

    nxt = cur;
    if (adv)   nxt.sec  = c_sec ? 8'h00 : bcd_inc(cur.sec);
    if (c_sec) nxt.mins = c_min ? 8'h00 : bcd_inc(cur.mins);
    if (c_min) nxt.hr   = c_hr ? 8'h00 : bcd_inc(cur.hr);
    if (c_hr) begin
      nxt.dow  = (cur.dow == 8'h07) ? 8'h01 : bcd_inc(cur.dow);
      nxt.date = c_date ? 8'h01 : bcd_inc(cur.date);
    end
    if (c_date) nxt.mon = c_mon ? 8'h01 : bcd_inc(cur.mon);
    if (c_mon)  nxt.yr  = c_yr ? 8'h00 : bcd_inc(cur.yr);
    if (c_yr)   nxt.cen = (cur.cen == 8'h39) ? 8'h00 : bcd_inc(cur.cen);
  end

  always_comb begin
    if (adv && time_ok(cur)) begin
      AST_CHAIN_LEGAL: assert (time_ok(nxt)); // R5
    end
  end

endmodule

// File: rtl/rtc_ram.sv
module rtc_ram #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 248
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/bcd_rtc_bank.sv
module bcd_rtc_bank
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);

  localparam int SPACE     = 2 ** ADDR_W;
  localparam int RAM_DEPTH = SPACE - 8;

  // reset: asserted asynchronously, released on clk
  logic [1:0] rst_sync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  // bus decode
  logic       wr_act, wr_act_q, wr_go, rd_en, in_clk, clk_wr, ram_we;
  logic [2:0] sel;
  assign wr_act = !ce_n && !we_n;
  assign wr_go  = wr_act && !wr_act_q;
  assign rd_en  = !ce_n && !oe_n && we_n;
  assign in_clk = &addr[ADDR_W-1:3];
  assign sel    = addr[2:0];
  assign clk_wr = wr_go && in_clk;
  assign ram_we = wr_go && !in_clk;

  // state
  rtc_time_t cnt_q, cnt_d, ld_q, ld_d, snap_q, snap_d, chain_nxt, view;
  logic stop_q, stop_d, w_q, w_d, r_q, r_d, ft_q, ft_d, adv;

  assign adv = tick_1hz && !stop_q && !w_q;

  rtc_chain u_chain (.cur(cnt_q), .adv(adv), .nxt(chain_nxt));

  always_comb begin
    cnt_d  = chain_nxt;
    ld_d   = ld_q;
    snap_d = snap_q;
    stop_d = stop_q;
    w_d    = w_q;
    r_d    = r_q;
    ft_d   = ft_q;
    if (clk_wr) begin
      case (sel)
        3'd0: begin
          w_d = dq_in[7];
          r_d = dq_in[6];
          if (dq_in[7]) begin
            if (!w_q) ld_d = cnt_q;
            ld_d.cen = {2'b00, dq_in[5:0]};
          end else if (w_q) begin
            cnt_d = ld_q;
          end
          if (dq_in[6] && !r_q) snap_d = cnt_q;
        end
        3'd1: begin
          stop_d = dq_in[7];
          if (w_q) ld_d.sec = {1'b0, dq_in[6:0]};
        end
        3'd2: if (w_q) ld_d.mins = {1'b0, dq_in[6:0]};
        3'd3: if (w_q) ld_d.hr = {2'b00, dq_in[5:0]};
        3'd4: begin
          ft_d = dq_in[6];
          if (w_q) ld_d.dow = {5'b00000, dq_in[2:0]};
        end
        3'd5: if (w_q) ld_d.date = {2'b00, dq_in[5:0]};
        3'd6: if (w_q) ld_d.mon = {3'b000, dq_in[4:0]};
        default: if (w_q) ld_d.yr = dq_in;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cnt_q    <= RTC_RESET;
      ld_q     <= RTC_RESET;
      snap_q   <= RTC_RESET;
      stop_q   <= 1'b0;
      w_q      <= 1'b0;
      r_q      <= 1'b0;
      ft_q     <= 1'b0;
      wr_act_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      ld_q     <= ld_d;
      snap_q   <= snap_d;
      stop_q   <= stop_d;
      w_q      <= w_d;
      r_q      <= r_d;
      ft_q     <= ft_d;
      wr_act_q <= wr_act;
    end
  end

  // RAM below the clock window
  logic [7:0] ram_rd;
  rtc_ram #(.ADDR_W(ADDR_W), .DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .addr(addr), .wdata(dq_in), .rdata(ram_rd)
  );

  // read path
  logic [7:0] clk_rd;
  assign view = w_q ? ld_q : (r_q ? snap_q : cnt_q);
  always_comb begin
    case (sel)
      3'd0:    clk_rd = view.cen | {w_q, r_q, 6'b0};
      3'd1:    clk_rd = view.sec | {stop_q, 7'b0};
      3'd2:    clk_rd = view.mins;
      3'd3:    clk_rd = view.hr;
      3'd4:    clk_rd = view.dow | {1'b1, ft_q, 6'b0};
      3'd5:    clk_rd = view.date;
      3'd6:    clk_rd = view.mon;
      default: clk_rd = view.yr;
    endcase
  end

  assign dq_oe  = rd_en;
  assign dq_out = rd_en ? (in_clk ? clk_rd : ram_rd) : 8'h00;

  // assertions
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_act && wr_act_q) |-> $stable(addr)); // R3
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (stop_q && !clk_wr) |=> $stable(cnt_q)); // R9
  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (w_q && !clk_wr) |=> $stable(cnt_q)); // R10
  AST_LOAD_XFER: assert property (@(posedge clk) disable iff (!rst_i_n)
    (clk_wr && sel == 3'd0 && !dq_in[7] && w_q) |=> (cnt_q == $past(ld_q))); // R10
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (r_q && !clk_wr) |=> $stable(snap_q)); // R11

endmodule

// File: tb/bcd_rtc_bank_bench.sv
module bcd_rtc_bank_bench;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 8;
  localparam int BASE   = 2 ** ADDR_W - 8;

  logic clk, rst_n, tick_1hz, ce_n, oe_n, we_n, dq_oe;
  logic [ADDR_W-1:0] addr;
  logic [7:0] dq_in, dq_out;

  bcd_rtc_bank #(.ADDR_W(ADDR_W)) u_bcd_rtc_bank (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // calendar model
  int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_cen;

  function automatic int days_in(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic model_tick();
    m_sec++;
    if (m_sec == 60) begin m_sec = 0; m_min++; end
    if (m_min == 60) begin m_min = 0; m_hr++; end
    if (m_hr == 24) begin
      m_hr = 0;
      m_dow = (m_dow == 7) ? 1 : m_dow + 1;
      m_date++;
      if (m_date > days_in(m_mon, m_yr)) begin m_date = 1; m_mon++; end
      if (m_mon == 13) begin m_mon = 1; m_yr++; end
      if (m_yr == 100) begin m_yr = 0; m_cen = (m_cen == 39) ? 0 : m_cen + 1; end
    end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(int a, logic [7:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); dq_in = d; ce_n = 0; we_n = 0;
    @(negedge clk);
    ce_n = 1; we_n = 1;
  endtask

  task automatic bus_read(int a, output logic [7:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); ce_n = 0; oe_n = 0; we_n = 1;
    #2;
    d = dq_out;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic do_tick();
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
  endtask

  task automatic set_time(int cen, int yr, int mon, int date, int dow, int hr, int mn, int sec);
    bus_write(BASE + 0, 8'h80 | bcd(cen));
    bus_write(BASE + 1, bcd(sec));
    bus_write(BASE + 2, bcd(mn));
    bus_write(BASE + 3, bcd(hr));
    bus_write(BASE + 4, bcd(dow));
    bus_write(BASE + 5, bcd(date));
    bus_write(BASE + 6, bcd(mon));
    bus_write(BASE + 7, bcd(yr));
    bus_write(BASE + 0, 8'h00);
    m_cen = cen; m_yr = yr; m_mon = mon; m_date = date;
    m_dow = dow; m_hr = hr; m_min = mn; m_sec = sec;
  endtask

  task automatic check_time(string req);
    logic [7:0] d;
    bus_read(BASE + 0, d); chk(req, d, bcd(m_cen));
    bus_read(BASE + 1, d); chk(req, d, bcd(m_sec));
    bus_read(BASE + 2, d); chk(req, d, bcd(m_min));
    bus_read(BASE + 3, d); chk(req, d, bcd(m_hr));
    bus_read(BASE + 4, d); chk(req, d, 8'h80 | bcd(m_dow));
    bus_read(BASE + 5, d); chk(req, d, bcd(m_date));
    bus_read(BASE + 6, d); chk(req, d, bcd(m_mon));
    bus_read(BASE + 7, d); chk(req, d, bcd(m_yr));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, ram_exp [BASE];
    logic [7:0] frozen_sec;
    void'($urandom(32'd4711));
    rst_n = 0; tick_1hz = 0; ce_n = 1; oe_n = 1; we_n = 1; addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R13 / R1 reset image
    m_cen = 0; m_yr = 0; m_mon = 1; m_date = 1; m_dow = 1; m_hr = 0; m_min = 0; m_sec = 0;
    check_time("R13");

    // R4 RAM, random addresses and data
    for (int i = 0; i < 20; i++) begin
      int a = $urandom_range(BASE - 1, 0);
      logic [7:0] v = 8'($urandom);
      bus_write(a, v);
      ram_exp[a] = v;
      bus_read(a, d); chk("R4", d, v);
    end

    // R2 bus drive rules
    @(negedge clk); addr = 8'h10; ce_n = 0; oe_n = 1; we_n = 1; #2;
    chk("R2 oe high", {7'b0, dq_oe}, 8'h00);
    ce_n = 1; oe_n = 0; #2;
    chk("R2 ce high", {7'b0, dq_oe}, 8'h00);
    ce_n = 0; #2;
    chk("R2 read", {7'b0, dq_oe}, 8'h01);
    @(negedge clk); dq_in = 8'h5A; we_n = 0; #2;
    chk("R2 write with oe low", {7'b0, dq_oe}, 8'h00);
    @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1;
    bus_read(8'h10, d); chk("R3 write with oe low", d, 8'h5A);

    // R3 held write commits once with first data; we falls before ce
    @(negedge clk); addr = 8'h20; dq_in = 8'hC3; we_n = 0;
    @(negedge clk); ce_n = 0;
    @(negedge clk); dq_in = 8'h3C;
    @(negedge clk); dq_in = 8'h99;
    @(negedge clk); ce_n = 1; we_n = 1;
    bus_read(8'h20, d); chk("R3 single commit", d, 8'hC3);

    // R5 R6 R7 R8 directed rollovers
    set_time(20, 23, 2, 28, 7, 23, 59, 59); do_tick(); model_tick(); check_time("R7 nonleap feb");
    set_time(20, 24, 2, 28, 3, 23, 59, 59); do_tick(); model_tick(); check_time("R7 leap feb28");
    do_tick(); model_tick(); check_time("R5 after leap");
    set_time(20, 24, 2, 29, 4, 23, 59, 59); do_tick(); model_tick(); check_time("R7 leap feb29");
    set_time(20, 31, 4, 30, 7, 23, 59, 59); do_tick(); model_tick(); check_time("R6 dow wrap 30-day");
    set_time(19, 99, 12, 31, 5, 23, 59, 59); do_tick(); model_tick(); check_time("R8 century carry");
    set_time(39, 99, 12, 31, 2, 23, 59, 59); do_tick(); model_tick(); check_time("R8 century wrap");
    set_time(21, 5, 6, 15, 3, 9, 59, 58); do_tick(); model_tick(); do_tick(); model_tick();
    check_time("R5 minute hour carry");

    // R9 stop bit; R12 field write ignored while load bit clear
    bus_write(BASE + 1, 8'h80 | 8'h33);
    bus_read(BASE + 1, d); chk("R12 stop set, seconds kept", d, 8'h80 | bcd(m_sec));
    do_tick(); do_tick();
    bus_read(BASE + 1, d); chk("R9 stopped", d, 8'h80 | bcd(m_sec));
    bus_write(BASE + 1, 8'h00);
    do_tick(); model_tick();
    check_time("R9 resumed");
    bus_write(BASE + 2, 8'h33);
    bus_read(BASE + 2, d); chk("R12 minutes write ignored", d, bcd(m_min));
    bus_write(BASE + 4, 8'h45);
    bus_read(BASE + 4, d); chk("R12 ft bit set, day kept", d, 8'hC0 | bcd(m_dow));
    bus_write(BASE + 4, 8'h00);
    bus_read(BASE + 4, d); chk("R1 ft cleared", d, 8'h80 | bcd(m_dow));

    // R11 freeze image
    bus_write(BASE + 0, 8'h40);
    bus_read(BASE + 1, frozen_sec);
    chk("R11 snap", frozen_sec, bcd(m_sec));
    repeat (3) begin do_tick(); model_tick(); end
    bus_read(BASE + 1, d); chk("R11 frozen", d, frozen_sec);
    bus_read(BASE + 0, d); chk("R11 ctrl read", d, 8'h40 | bcd(m_cen));
    bus_write(BASE + 0, 8'h00);
    check_time("R11 live after clear");

    // R10 load hold and readback
    bus_write(BASE + 0, 8'h80 | bcd(7));
    bus_write(BASE + 3, bcd(12));
    do_tick(); do_tick();
    bus_read(BASE + 3, d); chk("R10 loaded hour readback", d, bcd(12));
    bus_read(BASE + 1, d); chk("R10 seconds held", d, bcd(m_sec));
    bus_read(BASE + 0, d); chk("R10 ctrl read", d, 8'h80 | bcd(7));
    bus_write(BASE + 0, 8'h00);
    m_cen = 7; m_hr = 12;
    check_time("R10 transfer");

    // random legal times, random tick counts
    for (int i = 0; i < 40; i++) begin
      int yr = $urandom_range(99, 0);
      int mon = $urandom_range(12, 1);
      int dt = ($urandom_range(1, 0) == 1) ? days_in(mon, yr) : $urandom_range(days_in(mon, yr), 1);
      int hr = ($urandom_range(1, 0) == 1) ? 23 : $urandom_range(23, 0);
      int mn = ($urandom_range(1, 0) == 1) ? 59 : $urandom_range(59, 0);
      int sc = $urandom_range(59, 55);
      int n = $urandom_range(6, 1);
      set_time($urandom_range(39, 0), yr, mon, dt, $urandom_range(7, 1), hr, mn, sc);
      for (int k = 0; k < n; k++) begin do_tick(); model_tick(); end
      check_time("R5 R6 R7 R8 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule